// File: doc/BRIEF.md
# Exception Entry Controller

This block sits beside a processor pipeline and decides, every clock, which pending exception (if any) is entered next. It takes seven request sources: core reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. It also takes the current status word, the current program counter and a vector-base select. For the winning source it produces the handler address, the new status word with its mode field, the copy of the status word to be saved and the link value. All of these come from output registers, together with a one-cycle entry strobe.

The two interrupt inputs are active-low pins. A bypass input selects how they are sampled. When it is low, each pin passes through one register before arbitration. When it is high, the pins are already synchronous to the clock and feed the arbiter directly. The pipeline consumes the registered outputs on the cycle the strobe is high. While no unmasked request is pending, the strobe stays low and every output keeps its last value.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Priority, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, then undefined and software interrupt on the lowest level. When undefined and software interrupt are both requested, undefined is taken.
- R2: The handler address offset is 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt. Offset 0x14 is never produced.
- R3: With `hi_vec` low the vector base is 0x00000000. With `hi_vec` high it is 0xFFFF0000.
- R4: The mode field, status bits [4:0], becomes 10011 for reset and software interrupt, 11011 for undefined, 10111 for both aborts, 10010 for normal interrupt and 10001 for fast interrupt.
- R5: On entry, T (bit 5) is cleared and I (bit 7) is set. F (bit 6) is set for fast interrupt and reset; otherwise it keeps its current value. Bits [31:8] are copied unchanged.
- R6: For every non-reset entry, `saved_psr` equals the status word at the time the request was sampled.
- R7: For every non-reset entry, `link_val` is the sampled PC plus 8 for data abort and plus 4 for every other source.
- R8: `irq_n` and `fiq_n` are active low. With `pin_sync_bypass` high, a low pin yields an entry one clock after it is sampled, like any other request. With it low, the entry comes one clock later.
- R9: A normal interrupt is not taken while I is set, and a fast interrupt is not taken while F is set. A lower-priority source is then taken instead. Reset is taken whatever the mask bits are.
- R10: In a cycle with no unmasked request, `entry_stb` is low in the following cycle and all other outputs keep their previous values. After `rst_n`, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| reset_req | input | 1 | Core reset request |
| dabt_req | input | 1 | Data abort request |
| pabt_req | input | 1 | Prefetch abort request |
| und_req | input | 1 | Undefined instruction request |
| swi_req | input | 1 | Software interrupt request |
| irq_n | input | 1 | Normal interrupt pin, active low |
| fiq_n | input | 1 | Fast interrupt pin, active low |
| pin_sync_bypass | input | 1 | High: pins are synchronous, no extra stage |
| hi_vec | input | 1 | Selects the high vector base |
| cur_psr | input | 32 | Current status word |
| cur_pc | input | 32 | Current program counter |
| entry_stb | output | 1 | One-cycle pulse: outputs hold a new entry |
| vec_pc | output | 32 | Handler address |
| new_psr | output | 32 | Status word for the handler |
| saved_psr | output | 32 | Status word to save for the target mode |
| link_val | output | 32 | Link register value for the target mode |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a high vector base of 0xFFFF0000 and a link step of 4. With only seven request lines, two mask bits and one base select, it can sweep all 128 request patterns against every mask setting and both bases. That sweep covers every priority pairing, every masked-interrupt fall-through and every hold case. A separate pass drives the pins with the bypass low and confirms the extra cycle of latency for both interrupt lines.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int NUM_SRC = 7;
  localparam int MODE_W  = 5;
  localparam int T_BIT   = 5;
  localparam int F_BIT   = 6;
  localparam int I_BIT   = 7;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_RST  = 3'd1,
    EXC_DABT = 3'd2,
    EXC_FIQ  = 3'd3,
    EXC_IRQ  = 3'd4,
    EXC_PABT = 3'd5,
    EXC_UND  = 3'd6,
    EXC_SWI  = 3'd7
  } exc_kind_e;

  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;

  function automatic logic [4:0] vec_offset(exc_kind_e k);
    case (k)
      EXC_UND:  return 5'h04;
      EXC_SWI:  return 5'h08;
      EXC_PABT: return 5'h0C;
      EXC_DABT: return 5'h10;
      EXC_IRQ:  return 5'h18;
      EXC_FIQ:  return 5'h1C;
      default:  return 5'h00;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mode_code(exc_kind_e k);
    case (k)
      EXC_UND:            return MODE_UND;
      EXC_PABT, EXC_DABT: return MODE_ABT;
      EXC_IRQ:            return MODE_IRQ;
      EXC_FIQ:            return MODE_FIQ;
      default:            return MODE_SVC;
    endcase
  endfunction

endpackage

// File: rtl/exc_pin_sync.sv
module exc_pin_sync #(
  parameter int NUM_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bypass,
  input  logic [NUM_LINES-1:0] pin_n,
  output logic [NUM_LINES-1:0] req_o
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= 1'b1;
      else        stage_q <= pin_n[g];
    end
    assign req_o[g] = ~(bypass ? pin_n[g] : stage_q);

    // R8: with the stage in use, a request is one the pin showed a cycle earlier
    p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && req_o[g]) |-> $past(!pin_n[g]));
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,     // index 0 is highest priority
  input  logic               mask_i,
  input  logic               mask_f,
  output exc_kind_e          kind,
  output logic               take
);

  localparam int IDX_FIQ = int'(EXC_FIQ) - 1;
  localparam int IDX_IRQ = int'(EXC_IRQ) - 1;

  logic [NUM_SRC-1:0] req_m;
  logic [NUM_SRC-1:0] grant;

  always_comb begin
    req_m = req;
    req_m[IDX_FIQ] = req[IDX_FIQ] & ~mask_f;
    req_m[IDX_IRQ] = req[IDX_IRQ] & ~mask_i;
  end

  always_comb begin
    kind  = EXC_NONE;
    grant = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_m[i]) begin
        kind  = exc_kind_e'(3'(i + 1));
        grant = NUM_SRC'(1) << i;
      end
    end
  end

  assign take = (kind != EXC_NONE);

  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EXC_IRQ) |-> !mask_i);
  p_fiq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EXC_FIQ) |-> !mask_f);

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] HI_BASE   = 32'hFFFF_0000,
  parameter int              LINK_STEP = 4
) (
  input  exc_kind_e       kind,
  input  logic            hi_vec,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_psr,
  output logic [XLEN-1:0] vec_pc,
  output logic [XLEN-1:0] new_psr,
  output logic [XLEN-1:0] link_val
);

  localparam logic [XLEN-1:0] STEP_ONE = XLEN'(LINK_STEP);
  localparam logic [XLEN-1:0] STEP_TWO = XLEN'(2 * LINK_STEP);

  logic [XLEN-1:0] base;

  assign base   = hi_vec ? HI_BASE : '0;
  assign vec_pc = base | XLEN'(vec_offset(kind));

  always_comb begin
    new_psr               = cur_psr;
    new_psr[MODE_W-1:0]   = mode_code(kind);
    new_psr[T_BIT]        = 1'b0;
    new_psr[I_BIT]        = 1'b1;
    if (kind == EXC_FIQ || kind == EXC_RST) new_psr[F_BIT] = 1'b1;
  end

  assign link_val = cur_pc + ((kind == EXC_DABT) ? STEP_TWO : STEP_ONE);

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] HI_BASE   = 32'hFFFF_0000,
  parameter int              LINK_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reset_req,
  input  logic            dabt_req,
  input  logic            pabt_req,
  input  logic            und_req,
  input  logic            swi_req,
  input  logic            irq_n,
  input  logic            fiq_n,
  input  logic            pin_sync_bypass,
  input  logic            hi_vec,
  input  logic [XLEN-1:0] cur_psr,
  input  logic [XLEN-1:0] cur_pc,
  output logic            entry_stb,
  output logic [XLEN-1:0] vec_pc,
  output logic [XLEN-1:0] new_psr,
  output logic [XLEN-1:0] saved_psr,
  output logic [XLEN-1:0] link_val
);

  logic [1:0]         pin_req;   // [0] normal, [1] fast
  logic [NUM_SRC-1:0] req;
  exc_kind_e          kind;
  logic               take;
  logic [XLEN-1:0]    vec_d, psr_d, link_d;

  exc_pin_sync #(.NUM_LINES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .bypass (pin_sync_bypass),
    .pin_n  ({fiq_n, irq_n}),
    .req_o  (pin_req)
  );

  assign req = {swi_req, und_req, pabt_req, pin_req[0], pin_req[1], dabt_req, reset_req};

  exc_arbiter u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .mask_i (cur_psr[I_BIT]),
    .mask_f (cur_psr[F_BIT]),
    .kind   (kind),
    .take   (take)
  );

  exc_entry_calc #(.XLEN(XLEN), .HI_BASE(HI_BASE), .LINK_STEP(LINK_STEP)) u_calc (
    .kind     (kind),
    .hi_vec   (hi_vec),
    .cur_pc   (cur_pc),
    .cur_psr  (cur_psr),
    .vec_pc   (vec_d),
    .new_psr  (psr_d),
    .link_val (link_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_stb <= 1'b0;
      vec_pc    <= '0;
      new_psr   <= '0;
      saved_psr <= '0;
      link_val  <= '0;
    end else begin
      entry_stb <= take;
      if (take) begin
        vec_pc    <= vec_d;
        new_psr   <= psr_d;
        saved_psr <= cur_psr;
        link_val  <= link_d;
      end
    end
  end

  p_reset_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (entry_stb && vec_pc[4:0] == 5'h00));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (!entry_stb && $stable(vec_pc) && $stable(new_psr) && $stable(link_val)));
  p_entry_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    entry_stb |-> (new_psr[I_BIT] && !new_psr[T_BIT]));
  p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_stb |-> (vec_pc[4:0] != 5'h14));

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 0, dabt_req = 0, pabt_req = 0, und_req = 0, swi_req = 0;
  logic        irq_n = 1, fiq_n = 1, pin_sync_bypass = 1, hi_vec = 0;
  logic [31:0] cur_psr = 32'h0, cur_pc = 32'h0;
  logic        entry_stb;
  logic [31:0] vec_pc, new_psr, saved_psr, link_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .dabt_req(dabt_req),
    .pabt_req(pabt_req), .und_req(und_req), .swi_req(swi_req),
    .irq_n(irq_n), .fiq_n(fiq_n), .pin_sync_bypass(pin_sync_bypass),
    .hi_vec(hi_vec), .cur_psr(cur_psr), .cur_pc(cur_pc),
    .entry_stb(entry_stb), .vec_pc(vec_pc), .new_psr(new_psr),
    .saved_psr(saved_psr), .link_val(link_val)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns 0 none, 1 rst, 2 dabt, 3 fiq, 4 irq, 5 pabt, 6 und, 7 swi
  function automatic int pick(input logic [6:0] r, input logic ibit, input logic fbit);
    if (r[0]) return 1;
    if (r[1]) return 2;
    if (r[2] && !fbit) return 3;
    if (r[3] && !ibit) return 4;
    if (r[4]) return 5;
    if (r[5]) return 6;
    if (r[6]) return 7;
    return 0;
  endfunction

  function automatic logic [31:0] exp_off(input int k);
    case (k)
      2: return 32'h10; 3: return 32'h1C; 4: return 32'h18; 5: return 32'h0C;
      6: return 32'h04; 7: return 32'h08; default: return 32'h00;
    endcase
  endfunction

  function automatic logic [4:0] exp_mode(input int k);
    case (k)
      2, 5: return 5'b10111; 3: return 5'b10001; 4: return 5'b10010;
      6: return 5'b11011; default: return 5'b10011;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pv, pn, ps, pl;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(entry_stb == 0, "R10 reset strobe", {31'b0, entry_stb}, 0);
    chk(vec_pc == 0 && new_psr == 0, "R10 reset vec/psr", vec_pc | new_psr, 0);
    chk(saved_psr == 0 && link_val == 0, "R10 reset saved/link", saved_psr | link_val, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pv = 0; pn = 0; ps = 0; pl = 0;

    for (int hv = 0; hv < 2; hv++) begin
      for (int msk = 0; msk < 4; msk++) begin
        for (int c = 0; c < 128; c++) begin
          logic [6:0] r;
          int k;
          logic [31:0] psr, pc, ev, en;
          r   = 7'(c);
          psr = 32'h6A00_0000 | {24'h0, msk[1], msk[0], c[0], 5'b10000};
          pc  = 32'h0000_1000 + 32'(c) * 16 + 32'(msk) * 4;
          reset_req = r[0]; dabt_req = r[1]; fiq_n = ~r[2]; irq_n = ~r[3];
          pabt_req = r[4]; und_req = r[5]; swi_req = r[6];
          hi_vec = hv[0]; cur_psr = psr; cur_pc = pc;
          k = pick(r, psr[7], psr[6]);
          @(negedge clk);
          if (k == 0) begin
            chk(entry_stb == 0, "R10 no entry strobe", {31'b0, entry_stb}, 0);
            chk(vec_pc == pv && new_psr == pn && saved_psr == ps && link_val == pl,
                "R10 outputs held", vec_pc, pv);
          end else begin
            ev = (hv != 0 ? 32'hFFFF_0000 : 32'h0) + exp_off(k);
            en = {psr[31:8], 8'h80} | ((k == 1 || k == 3) ? 32'h40 : (psr & 32'h40)) | {27'b0, exp_mode(k)};
            chk(entry_stb == 1, "R1 R9 strobe", {31'b0, entry_stb}, 1);
            chk(vec_pc == ev, "R1 R2 R3 vector", vec_pc, ev);
            chk(new_psr == en, "R4 R5 new status", new_psr, en);
            if (k != 1) begin
              chk(saved_psr == psr, "R6 saved status", saved_psr, psr);
              chk(link_val == pc + ((k == 2) ? 32'd8 : 32'd4), "R7 link", link_val,
                  pc + ((k == 2) ? 32'd8 : 32'd4));
            end
            pv = vec_pc; pn = new_psr; ps = saved_psr; pl = link_val;
          end
        end
      end
    end

    // R8 synchroniser stage in use
    reset_req = 0; dabt_req = 0; pabt_req = 0; und_req = 0; swi_req = 0;
    irq_n = 1; fiq_n = 1; hi_vec = 0; cur_psr = 32'h0000_0010;
    pin_sync_bypass = 0;
    repeat (2) @(negedge clk);
    for (int line = 0; line < 2; line++) begin
      logic [31:0] ev;
      ev = (line == 0) ? 32'h18 : 32'h1C;
      if (line == 0) irq_n = 0; else fiq_n = 0;
      @(negedge clk);
      chk(entry_stb == 0, "R8 sync delays entry", {31'b0, entry_stb}, 0);
      @(negedge clk);
      chk(entry_stb == 1, "R8 sync entry strobe", {31'b0, entry_stb}, 1);
      chk(vec_pc == ev, "R8 sync vector", vec_pc, ev);
      irq_n = 1; fiq_n = 1;
      repeat (3) @(negedge clk);
      chk(entry_stb == 0, "R8 sync released", {31'b0, entry_stb}, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule